// File: doc/BRIEF.md
# Network Controller Interrupt Status Register Block

This block holds the control and status registers of a network controller. The transmit and receive engines report events as single-cycle pulses on an event vector. Each pulse sets a sticky flag in the status word. Two summary bits are derived from fixed groups of flags, and a registered level interrupt is raised whenever either summary is set.

Software reaches the sixteen registers through a simple word port. The port takes a byte offset and 32-bit data, with registers spaced eight bytes apart. Status flags are cleared by writing ones to them. The receive and transmit process-state fields of the status word are not stored: they are formed at read time from the start bits of the operating-mode register. The missed-frame register returns zero on a read and is cleared by that read. All other registers are plain storage with fixed reset values.

Top module: `nic_irq_status`

## Requirements
- R1: After reset, register 0 reads 0xFFF80000, the status register (index 5, offset 0x28) reads 0xFC000000, and `irq` is low.
- R2: Each event bit at a defined position sets the status flag at the same bit position, and the flag is visible on a read one clock after the pulse. The defined positions are: 0 tx done, 1 tx stopped, 2 tx buffer unavailable, 3 jabber timeout, 5 underflow, 6 rx done, 7 rx buffer unavailable, 8 rx stopped, 9 rx watchdog, 11 timer expired, 13 fatal bus error.
- R3: Event bits 4, 10 and 12 are ignored.
- R4: Status bit 16 (normal summary) is 1 exactly when any of flags 0, 2 or 6 is set.
- R5: Status bit 15 (abnormal summary) is 1 exactly when any of flags 1, 3, 5, 7, 8, 9, 11 or 13 is set.
- R6: A write to the status register clears every stored bit that is 1 in the written data. The summary bits cannot be set by a write; they are always recomputed from the flags.
- R7: An event pulse in the same cycle as a clearing write to the same flag leaves the flag set.
- R8: `irq` is a register that equals bit 15 OR bit 16 of the status word as it stood one clock earlier.
- R9: A status read ORs the value 3 into bits 19:17 when bit 1 of the mode register (index 6) is set, and the value 3 into bits 22:20 when bit 13 of the mode register is set.
- R10: A read of the missed-frame register (index 8) returns 0 and clears the stored value.
- R11: Other registers store written data and read it back. An offset that is not a multiple of 8, or that is 0x80 or above, reads 0 and its write changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe (triggers read side effects) |
| acc_off | input | 8 | Byte offset of the accessed register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_off`, combinational |
| evt | input | 14 | Event pulses, one per status flag position |
| irq | output | 1 | Level interrupt request |

## Verification
A table drives event pulses and clearing writes in sequence. It walks through each normal flag alone, each abnormal flag alone, and both groups together. This shows that each summary follows only its own group and drops to zero as soon as its last flag clears. Some rows collide an event with a clear of the same bit. Other rows pulse only the undefined event bits, or write ones into the summary positions. These rows separate event priority, event masking and summary recomputation from plain storage. Directed tests then cover all four combinations of the mode start bits, the read-clear register, and offsets that alias a valid register once the high or low bits are dropped.

// File: rtl/nic_irq_status.sv
module nic_irq_status #(
  parameter int NREG     = 16,
  parameter int STRIDE   = 8,
  parameter int OFF_W    = 8,
  parameter int STS_IDX  = 5,
  parameter int MODE_IDX = 6,
  parameter int MISS_IDX = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_wr,
  input  logic        acc_rd,
  input  logic [7:0]  acc_off,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  input  logic [13:0] evt,
  output logic        irq
);
  localparam int SH = $clog2(STRIDE);
  localparam int IW = $clog2(NREG);
  localparam logic [31:0] NORM_M   = 32'h0000_0045;
  localparam logic [31:0] ABN_M    = 32'h0000_2BAA;
  localparam logic [31:0] FLAG_M   = NORM_M | ABN_M;
  localparam logic [31:0] R0_RST   = 32'hFFF8_0000;
  localparam logic [31:0] STS_RST  = 32'hFC00_0000;
  localparam logic [31:0] MISS_RST = 32'hFFFE_0000;

  logic [31:0] rf [NREG];
  logic        hit;
  logic [IW-1:0] idx;
  logic [31:0] sts_q, mode_q, evt_m, clr_m, raw, sts_nxt, run;

  assign hit   = (acc_off[SH-1:0] == '0) && ((acc_off >> SH) < OFF_W'(NREG));
  assign idx   = acc_off[SH+IW-1:SH];
  assign sts_q  = rf[STS_IDX];
  assign mode_q = rf[MODE_IDX];
  assign evt_m = {18'b0, evt} & FLAG_M;
  assign clr_m = (acc_wr && hit && idx == IW'(STS_IDX)) ? acc_wdata : '0;
  assign raw   = (sts_q & ~clr_m) | evt_m;
  assign sts_nxt = {raw[31:17], |(raw & NORM_M), |(raw & ABN_M), raw[14:0]};
  assign run   = (mode_q[13] ? 32'h0030_0000 : '0) | (mode_q[1] ? 32'h0006_0000 : '0);

  always_comb begin
    acc_rdata = '0;
    if (hit) begin
      if (idx == IW'(STS_IDX))       acc_rdata = sts_q | run;
      else if (idx != IW'(MISS_IDX)) acc_rdata = rf[idx];
    end
  end

  function automatic logic [31:0] rst_val(int i);
    if (i == 0)        return R0_RST;
    if (i == STS_IDX)  return STS_RST;
    if (i == MISS_IDX) return MISS_RST;
    return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= rst_val(i);
      irq <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (i == STS_IDX)
          rf[i] <= sts_nxt;
        else if (acc_wr && hit && idx == IW'(i))
          rf[i] <= acc_wdata;
        else if (i == MISS_IDX && acc_rd && hit && idx == IW'(i))
          rf[i] <= '0;
      end
      irq <= sts_q[16] | sts_q[15];
    end
  end

  // R4
  norm_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[16] == |(sts_q & NORM_M));
  // R5
  abn_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[15] == |(sts_q & ABN_M));
  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_m != '0) |=> ((sts_q & $past(clr_m & FLAG_M & ~evt_m)) == '0));
  // R7
  evt_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_m != '0) |=> ((sts_q & $past(evt_m)) == $past(evt_m)));
  // R8
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(sts_q & FLAG_M))));
  // R10
  miss_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_wr && hit && idx == IW'(MISS_IDX)) |=> (rf[MISS_IDX] == '0));
endmodule

// File: tb/nic_irq_status_test.sv
module nic_irq_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0, acc_rd = 1'b0;
  logic [7:0]  acc_off = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [13:0] evt = '0;
  logic        irq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  nic_irq_status uut (.clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_off(acc_off), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .evt(evt), .irq(irq));

  // {event pulse, status clear data, expected status read}
  localparam logic [77:0] TBL [14] = '{
    {14'h0001, 32'h0000_0000, 32'hFC01_0001},
    {14'h0000, 32'h0000_0001, 32'hFC00_0000},
    {14'h0002, 32'h0000_0000, 32'hFC00_8002},
    {14'h0040, 32'h0000_0000, 32'hFC01_8042},
    {14'h0000, 32'h0000_0002, 32'hFC01_0040},
    {14'h0004, 32'h0000_0040, 32'hFC01_0004},
    {14'h2000, 32'h0000_0004, 32'hFC00_A000},
    {14'h0001, 32'h0000_0001, 32'hFC01_A001},
    {14'h1410, 32'h0000_2001, 32'hFC00_0000},
    {14'h0200, 32'h0001_8000, 32'hFC00_8200},
    {14'h0000, 32'hFFFF_FFFF, 32'h0000_0000},
    {14'h0B28, 32'h0000_0000, 32'h0000_8B28},
    {14'h0080, 32'h0000_0000, 32'h0000_8BA8},
    {14'h0000, 32'h0000_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk); acc_off = off; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk); acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, input string tag, input logic [31:0] exp);
    @(negedge clk); acc_off = off; acc_rd = 1'b1;
    #1 chk(tag, acc_rdata, exp);
    @(negedge clk); acc_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h00, "R1 reg0 reset", 32'hFFF8_0000);
    rd(8'h28, "R1 status reset", 32'hFC00_0000);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      evt = TBL[i][77:64];
      acc_off = 8'h28;
      acc_wdata = TBL[i][63:32];
      acc_wr = (TBL[i][63:32] != '0);
      @(negedge clk);
      evt = '0; acc_wr = 1'b0;
      chk($sformatf("R2 R3 R4 R5 R6 R7 row %0d", i), acc_rdata, TBL[i][31:0]);
      @(negedge clk);
      chk($sformatf("R8 irq row %0d", i), {31'b0, irq}, {31'b0, TBL[i][16] | TBL[i][15]});
    end

    wr(8'h30, 32'h0000_0002);
    rd(8'h28, "R9 rx run", 32'h0006_0000);
    wr(8'h30, 32'h0000_2000);
    rd(8'h28, "R9 tx run", 32'h0030_0000);
    wr(8'h30, 32'h0000_2002);
    rd(8'h28, "R9 both run", 32'h0036_0000);
    wr(8'h30, 32'h0000_0000);
    rd(8'h28, "R9 none run", 32'h0000_0000);

    wr(8'h40, 32'h0000_1234);
    rd(8'h40, "R10 miss read", 32'h0);
    rd(8'h40, "R10 miss reread", 32'h0);

    wr(8'h18, 32'hDEAD_BEEF);
    rd(8'h18, "R11 reg3 rw", 32'hDEAD_BEEF);
    wr(8'h1C, 32'h0000_0055);
    rd(8'h18, "R11 unaligned write", 32'hDEAD_BEEF);
    rd(8'h1C, "R11 unaligned read", 32'h0);
    wr(8'h80, 32'h0000_0001);
    rd(8'h00, "R11 out of range write", 32'hFFF8_0000);
    wr(8'hF8, 32'h0000_0007);
    rd(8'h78, "R11 high alias", 32'h0);
    rd(8'hF8, "R11 out of range read", 32'h0);

    @(negedge clk); evt = 14'h0001;
    @(negedge clk); evt = '0;
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h28, "R11 unaligned status clear", 32'h0001_0001);
    chk("R8 irq held", {31'b0, irq}, 32'h1);

    finish_run();
  end
endmodule